// File: doc/BRIEF.md
# Video AGC Gain Controller

This block closes a digital automatic gain control loop around a sampled video input. Once per line, upstream logic delivers the ADC code measured at the sync tip and the code measured at the back porch, together with a one-cycle strobe. The controller compares the porch-minus-tip amplitude with a selectable target. It then nudges an 8-bit gain word up or down by one step, or leaves it alone when the amplitude is already on target.

An ADC overflow flag, sampled with the strobe, can force a larger cut in gain. When overflow priority is enabled, this cut replaces the normal tracking step for that line. A freeze control stops the loop. While frozen, the gain becomes a plain register that a host can overwrite through a small write/read port. The same gain word drives both the luminance and the chrominance gain outputs, so freezing holds both. Selecting the default state of the control inputs after reset is left to the parent block.

Top module: `vagc_top`

## Requirements
- R1: After reset the gain is 128 on `gain_y`, `gain_c` and `host_rdata`.
- R2: The loop acts only on a strobe with `ctl_freeze`=0 and no overflow-priority event, and only with `ctl_low_tgt`=0. In that case the amplitude porch_code minus tip_code, taken as a signed value, is compared with 68. Below 68 raises the gain by 1, above 68 lowers it by 1, and equal to 68 leaves it unchanged. A negative amplitude counts as below target.
- R3: With `ctl_low_tgt`=1 the comparison target is 54 instead of 68. The direction rules are the same.
- R4: On a strobe with `ctl_freeze`=0, `ctl_ovf_prio`=1 and `adc_ovf`=1, the gain drops by 4 and clamps at 0. The amplitude comparison is skipped for that line.
- R5: With `ctl_ovf_prio`=0, `adc_ovf` has no effect and the strobe applies the R2/R3 tracking step.
- R6: Tracking saturates, so the gain never rises above 255 and never falls below 0.
- R7: The gain changes only on a strobe or a host load. A strobe's result appears on the outputs in the cycle after the strobe. At most one update happens per strobe, and `adc_ovf` without a strobe has no effect.
- R8: With `ctl_freeze`=1, strobes (including overflow) leave the gain unchanged.
- R9: With `ctl_freeze`=1, `host_wr`=1 loads `host_wdata` into the gain in the next cycle. The value stays until the next load or, after unfreezing, the next strobe.
- R10: With `ctl_freeze`=0, `host_wr` is ignored.
- R11: `host_rdata`, `gain_y` and `gain_c` always show the current gain, both frozen and running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_vld | input | 1 | One-cycle per-line measurement strobe |
| tip_code | input | 10 | ADC code at sync tip |
| porch_code | input | 10 | ADC code at back porch |
| adc_ovf | input | 1 | ADC overflow flag, sampled with the strobe |
| ctl_low_tgt | input | 1 | 1 selects the 54-code target, 0 the 68-code target |
| ctl_ovf_prio | input | 1 | 1 enables overflow-driven reduction |
| ctl_freeze | input | 1 | 1 holds the loop and enables host writes |
| host_wr | input | 1 | Host write strobe for the gain register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Current gain for host read |
| gain_y | output | 8 | Gain to the luminance path |
| gain_c | output | 8 | Gain to the chrominance path |

## Verification
The tracking path is driven with amplitudes below, at and above each target. This includes a negative amplitude, and amplitudes of 54 and 60 that produce opposite steps under the two targets, which separates a wrong target selection from a wrong comparison direction. Overflow cases repeat an amplitude that alone would raise the gain, so an overflow cut of 4 cannot be mistaken for tracking, and the same pattern with priority off shows that the flag is ignored. Host-loaded gains of 255, 0 and 2 push the loop against both rails and the overflow floor. Freeze, unfrozen writes and overflow without a strobe are each checked to leave the read-back gain untouched.

// File: rtl/vagc_pkg.sv
`timescale 1ns/1ps
// vagc_pkg: shared types for the video AGC gain controller.
// Assumes: one decision is produced per measured line.
package vagc_pkg;
    // Per-line gain decision handed from the comparator to the accumulator.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_OVF  = 2'd3
    } vagc_step_t;
endpackage

// File: rtl/vagc_level_cmp.sv
`timescale 1ns/1ps
// vagc_level_cmp: turns one line's tip/porch measurement into a gain decision.
// Overflow (when enabled) overrides the amplitude comparison.
// Assumes: codes are unsigned; targets fit in ADC_W bits.
module vagc_level_cmp
    import vagc_pkg::*;
#(
    parameter int ADC_W    = 10,
    parameter int TGT_NORM = 68,
    parameter int TGT_LOW  = 54
) (
    input  logic [ADC_W-1:0] tip_code,
    input  logic [ADC_W-1:0] porch_code,
    input  logic             low_tgt,
    input  logic             ovf_prio,
    input  logic             adc_ovf,
    output vagc_step_t       step
);
    localparam int DIFF_W = ADC_W + 1;

    logic signed [DIFF_W-1:0] amp;
    logic signed [DIFF_W-1:0] target;

    // Signed amplitude of the line and the selected target.
    always_comb begin
        amp    = $signed({1'b0, porch_code}) - $signed({1'b0, tip_code});
        target = low_tgt ? $signed(DIFF_W'(TGT_LOW)) : $signed(DIFF_W'(TGT_NORM));
    end

    // Decision: overflow first, then direction of the amplitude error.
    always_comb begin
        if (ovf_prio && adc_ovf) begin
            step = STEP_OVF;
        end else if (amp < target) begin
            step = STEP_UP;
        end else if (amp > target) begin
            step = STEP_DOWN;
        end else begin
            step = STEP_HOLD;
        end
    end
endmodule

// File: rtl/vagc_upd_gate.sv
`timescale 1ns/1ps
// vagc_upd_gate: decides which source may change the gain this cycle.
// Running: only the line strobe. Frozen: only a host write.
module vagc_upd_gate (
    input  logic meas_vld,
    input  logic freeze,
    input  logic host_wr,
    output logic loop_en,
    output logic host_ld
);
    // Freeze switches ownership of the gain from the loop to the host.
    always_comb begin
        loop_en = meas_vld && !freeze;
        host_ld = host_wr && freeze;
    end
endmodule

// File: rtl/vagc_gain_acc.sv
`timescale 1ns/1ps
// vagc_gain_acc: the gain register with saturating steps and host load.
// Assumes: loop_en and host_ld are never both set (guaranteed by the gate).
module vagc_gain_acc
    import vagc_pkg::*;
#(
    parameter int GAIN_W   = 8,
    parameter int GAIN_RST = 128,
    parameter int TRK_STEP = 1,
    parameter int OVF_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  vagc_step_t        step,
    input  logic              host_ld,
    input  logic [GAIN_W-1:0] host_val,
    output logic [GAIN_W-1:0] gain
);
    localparam int SUM_W    = GAIN_W + 2;
    localparam int GAIN_MAX = (1 << GAIN_W) - 1;

    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;
    logic [GAIN_W-1:0]       stepped;

    // Signed size of the step for this decision.
    always_comb begin
        unique case (step)
            STEP_UP:   delta = $signed(SUM_W'(TRK_STEP));
            STEP_DOWN: delta = -$signed(SUM_W'(TRK_STEP));
            STEP_OVF:  delta = -$signed(SUM_W'(OVF_STEP));
            default:   delta = '0;
        endcase
    end

    // Apply the step and clamp to the gain range.
    always_comb begin
        sum = $signed({2'b00, gain}) + delta;
        if (sum < 0) begin
            stepped = '0;
        end else if (sum > $signed(SUM_W'(GAIN_MAX))) begin
            stepped = GAIN_W'(GAIN_MAX);
        end else begin
            stepped = sum[GAIN_W-1:0];
        end
    end

    // Gain register: reset to mid-scale, else host load or loop step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= GAIN_W'(GAIN_RST);
        end else if (host_ld) begin
            gain <= host_val;
        end else if (loop_en) begin
            gain <= stepped;
        end
    end
endmodule

// File: rtl/vagc_top.sv
`timescale 1ns/1ps
// vagc_top: per-line video AGC loop with overflow priority and host freeze.
// One gain word feeds both luminance and chrominance paths.
// Assumes: meas_vld is a one-cycle pulse per line; adc_ovf is valid with it.
module vagc_top
    import vagc_pkg::*;
#(
    parameter int ADC_W    = 10,
    parameter int GAIN_W   = 8,
    parameter int TGT_NORM = 68,
    parameter int TGT_LOW  = 54,
    parameter int TRK_STEP = 1,
    parameter int OVF_STEP = 4,
    parameter int GAIN_RST = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_vld,
    input  logic [ADC_W-1:0]  tip_code,
    input  logic [ADC_W-1:0]  porch_code,
    input  logic              adc_ovf,
    input  logic              ctl_low_tgt,
    input  logic              ctl_ovf_prio,
    input  logic              ctl_freeze,
    input  logic              host_wr,
    input  logic [GAIN_W-1:0] host_wdata,
    output logic [GAIN_W-1:0] host_rdata,
    output logic [GAIN_W-1:0] gain_y,
    output logic [GAIN_W-1:0] gain_c
);
    vagc_step_t        step;
    logic              loop_en;
    logic              host_ld;
    logic [GAIN_W-1:0] gain;

    vagc_level_cmp #(
        .ADC_W   (ADC_W),
        .TGT_NORM(TGT_NORM),
        .TGT_LOW (TGT_LOW)
    ) u_cmp (
        .tip_code  (tip_code),
        .porch_code(porch_code),
        .low_tgt   (ctl_low_tgt),
        .ovf_prio  (ctl_ovf_prio),
        .adc_ovf   (adc_ovf),
        .step      (step)
    );

    vagc_upd_gate u_gate (
        .meas_vld(meas_vld),
        .freeze  (ctl_freeze),
        .host_wr (host_wr),
        .loop_en (loop_en),
        .host_ld (host_ld)
    );

    vagc_gain_acc #(
        .GAIN_W  (GAIN_W),
        .GAIN_RST(GAIN_RST),
        .TRK_STEP(TRK_STEP),
        .OVF_STEP(OVF_STEP)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_en (loop_en),
        .step    (step),
        .host_ld (host_ld),
        .host_val(host_wdata),
        .gain    (gain)
    );

    // Fan the single gain word out to both paths and the read port.
    always_comb begin
        gain_y     = gain;
        gain_c     = gain;
        host_rdata = gain;
    end
endmodule

// File: rtl/vagc_chk.sv
`timescale 1ns/1ps
// vagc_chk: port-level properties of vagc_top, attached by bind below.
module vagc_chk #(
    parameter int ADC_W    = 10,
    parameter int GAIN_W   = 8,
    parameter int OVF_STEP = 4,
    parameter int GAIN_RST = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              meas_vld,
    input logic              adc_ovf,
    input logic              ctl_ovf_prio,
    input logic              ctl_freeze,
    input logic              host_wr,
    input logic [GAIN_W-1:0] host_wdata,
    input logic [GAIN_W-1:0] gain_y
);
    a_r1_reset_mid: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> gain_y == GAIN_W'(GAIN_RST));

    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_vld && !host_wr) |=> $stable(gain_y));

    a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_freeze && !host_wr) |=> $stable(gain_y));

    a_r10_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_freeze && !meas_vld) |=> $stable(gain_y));

    a_r9_host_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_freeze && host_wr) |=> gain_y == $past(host_wdata));

    a_r4_ovf_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld && !ctl_freeze && ctl_ovf_prio && adc_ovf && gain_y >= GAIN_W'(OVF_STEP))
        |=> gain_y == $past(gain_y) - GAIN_W'(OVF_STEP));

    a_r4_ovf_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld && !ctl_freeze && ctl_ovf_prio && adc_ovf && gain_y < GAIN_W'(OVF_STEP))
        |=> gain_y == '0);
endmodule

bind vagc_top vagc_chk #(
    .ADC_W   (ADC_W),
    .GAIN_W  (GAIN_W),
    .OVF_STEP(OVF_STEP),
    .GAIN_RST(GAIN_RST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_vld    (meas_vld),
    .adc_ovf     (adc_ovf),
    .ctl_ovf_prio(ctl_ovf_prio),
    .ctl_freeze  (ctl_freeze),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .gain_y      (gain_y)
);

// File: tb/tb_vagc_top.sv
`timescale 1ns/1ps
module tb_vagc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       meas_vld = 1'b0;
    logic [9:0] tip_code = '0;
    logic [9:0] porch_code = '0;
    logic       adc_ovf = 1'b0;
    logic       ctl_low_tgt = 1'b0;
    logic       ctl_ovf_prio = 1'b1;
    logic       ctl_freeze = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] gain_y;
    logic [7:0] gain_c;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vagc_top dut (
        .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld),
        .tip_code(tip_code), .porch_code(porch_code), .adc_ovf(adc_ovf),
        .ctl_low_tgt(ctl_low_tgt), .ctl_ovf_prio(ctl_ovf_prio),
        .ctl_freeze(ctl_freeze), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .gain_y(gain_y), .gain_c(gain_c)
    );

    // {req[3:0], low, prio, ovf, tip[9:0], porch[9:0], expected gain[7:0]}
    localparam int NV = 12;
    localparam logic [34:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b1, 1'b0, 10'd100, 10'd150, 8'd129}, // R2 amp 50 below 68
        {4'd2, 1'b0, 1'b1, 1'b0, 10'd100, 10'd200, 8'd128}, // R2 amp 100 above
        {4'd2, 1'b0, 1'b1, 1'b0, 10'd64,  10'd132, 8'd128}, // R2 amp 68 hold
        {4'd3, 1'b1, 1'b1, 1'b0, 10'd100, 10'd154, 8'd128}, // R3 amp 54 hold
        {4'd3, 1'b1, 1'b1, 1'b0, 10'd100, 10'd160, 8'd127}, // R3 amp 60 above 54
        {4'd2, 1'b0, 1'b1, 1'b0, 10'd100, 10'd160, 8'd128}, // R2 amp 60 below 68
        {4'd4, 1'b0, 1'b1, 1'b1, 10'd100, 10'd150, 8'd124}, // R4 overflow wins
        {4'd5, 1'b0, 1'b0, 1'b1, 10'd100, 10'd150, 8'd125}, // R5 flag ignored
        {4'd5, 1'b0, 1'b0, 1'b1, 10'd100, 10'd200, 8'd124}, // R5 flag ignored
        {4'd2, 1'b0, 1'b1, 1'b0, 10'd300, 10'd200, 8'd125}, // R2 negative amp
        {4'd4, 1'b0, 1'b1, 1'b1, 10'd64,  10'd132, 8'd121}, // R4 at target
        {4'd4, 1'b1, 1'b1, 1'b1, 10'd100, 10'd154, 8'd117}  // R4 low target
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One line strobe; returns at the negedge after the updating edge.
    task automatic line(input logic lo, input logic pr, input logic ov,
                        input logic [9:0] t, input logic [9:0] p);
        @(negedge clk);
        ctl_low_tgt = lo; ctl_ovf_prio = pr; adc_ovf = ov;
        tip_code = t; porch_code = p; meas_vld = 1'b1;
        @(negedge clk);
        meas_vld = 1'b0; adc_ovf = 1'b0;
    endtask

    task automatic hwrite(input logic [7:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 gain_y", gain_y, 8'd128);
        check("R1 gain_c", gain_c, 8'd128);
        check("R11 rdata", host_rdata, 8'd128);

        for (int i = 0; i < NV; i++) begin
            line(VEC[i][30], VEC[i][29], VEC[i][28], VEC[i][27:18], VEC[i][17:8]);
            check($sformatf("R%0d vec%0d", VEC[i][34:31], i), gain_y, VEC[i][7:0]);
        end
        check("R11 gain_c after vectors", gain_c, 8'd117);

        // R7: overflow with no strobe changes nothing.
        @(negedge clk); ctl_ovf_prio = 1'b1; adc_ovf = 1'b1;
        @(negedge clk); adc_ovf = 1'b0;
        @(negedge clk);
        check("R7 ovf without strobe", gain_y, 8'd117);

        // R10: host write while running is ignored.
        hwrite(8'd200);
        @(negedge clk);
        check("R10 unfrozen write", host_rdata, 8'd117);

        // R8: frozen gain ignores strobes, with and without overflow.
        ctl_freeze = 1'b1;
        line(1'b0, 1'b1, 1'b0, 10'd100, 10'd150);
        check("R8 frozen track", gain_y, 8'd117);
        line(1'b0, 1'b1, 1'b1, 10'd100, 10'd150);
        check("R8 frozen ovf", gain_c, 8'd117);

        // R9: host load while frozen, held until a strobe after unfreeze.
        hwrite(8'd200);
        check("R9 load", host_rdata, 8'd200);
        check("R11 gain_y follows load", gain_y, 8'd200);
        @(negedge clk); ctl_freeze = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 held after unfreeze", gain_y, 8'd200);
        line(1'b0, 1'b1, 1'b0, 10'd100, 10'd150);
        check("R9 loop resumes", gain_y, 8'd201);

        // R6: saturation at both rails.
        ctl_freeze = 1'b1; hwrite(8'd255); ctl_freeze = 1'b0;
        line(1'b0, 1'b1, 1'b0, 10'd100, 10'd150);
        check("R6 top rail", gain_y, 8'd255);
        ctl_freeze = 1'b1; hwrite(8'd0); ctl_freeze = 1'b0;
        line(1'b0, 1'b1, 1'b0, 10'd100, 10'd200);
        check("R6 bottom rail", gain_y, 8'd0);

        // R4: overflow cut clamps at zero.
        ctl_freeze = 1'b1; hwrite(8'd2); ctl_freeze = 1'b0;
        line(1'b0, 1'b1, 1'b1, 10'd100, 10'd150);
        check("R4 ovf floor", gain_y, 8'd0);

        // R1: reset in mid-run returns to mid-scale.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", host_rdata, 8'd128);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule